// File: doc/BRIEF.md
# Machine-Mode Trap and CSR Unit

This unit holds the privileged control state of a small single-issue 32-bit core with two privilege levels, machine and user. It keeps the trap-return address, the trap cause, the handler base address and the status word. The status word holds the interrupt enable, the saved interrupt enable and the saved privilege. The unit sits beside the commit point of the pipeline. Each cycle the pipeline presents at most one instruction (`valid_i`, `pc_i`) together with what it is: a CSR access, an environment call, a return-from-trap, or an instruction the decoder already found illegal.

In the same cycle the unit decides whether that instruction retires, raises an exception, or is displaced by the timer interrupt. On a trap it signals a redirect to the handler base. On a legal return it signals a redirect to the saved address. All state changes land on the following clock edge. CSR accesses made from user mode, accesses to unknown CSR addresses, and returns made from user mode become illegal-instruction traps. None of them changes any state. Interrupts are taken only at an instruction boundary, which means a cycle with `valid_i` high.

CSR addresses: status 0x300, handler base 0x305, return address 0x341, cause 0x342. Status bit fields: interrupt enable at bit 3, saved enable at bit 7, saved privilege at bits 12:11. Privilege codes: 2'b11 is machine and 2'b00 is user. CSR operation codes: 0 write, 1 set bits, 2 clear bits, 3 read only.

Top module: `mtrap_csr_unit`

## Requirements
- R1: While and after reset, `priv_o` is 2'b11, and the status, handler base, return address and cause CSRs all read 0.
- R2: In machine mode, a CSR access to a known address retires, and `csr_rdata_o` gives the old value in that cycle. The write (op 0), set (op 1) or clear (op 2) takes effect at the next edge; op 3 changes nothing.
- R3: A CSR access to any address other than 0x300, 0x305, 0x341 or 0x342 traps with cause 2 and writes nothing.
- R4: A CSR access or a return-from-trap issued in user mode traps with cause 2 and changes no CSR other than through the trap itself.
- R5: An environment call traps with cause 8 from user mode and cause 11 from machine mode.
- R6: A trap raises `trap_o` and `redirect_o`, drives `redirect_pc_o` to the handler base, and keeps `retire_o` low. It stores `pc_i` with bits 1:0 cleared as the return address and the cause in the cause CSR. From the next cycle `priv_o` is 2'b11.
- R7: A trap copies the interrupt enable into the saved enable, clears the interrupt enable, and stores the prior privilege in the saved-privilege field.
- R8: A return-from-trap in machine mode retires and redirects to the return address. At the next edge it sets privilege from the saved-privilege field, restores the interrupt enable from the saved enable, sets the saved enable to 1, and sets the saved privilege to user.
- R9: With `valid_i` high, the timer line traps with cause 0x80000007 when the interrupt enable is set or the privilege is user. In machine mode with the enable clear it has no effect.
- R10: A synchronous exception in the same cycle as a takeable timer interrupt wins: its cause is recorded and the timer stays pending.
- R11: `illegal_i` traps with cause 2, ahead of an environment call in the same cycle.
- R12: The saved-privilege field keeps only 2'b11, and any other written value becomes 2'b00. The handler base and return address always read with bits 1:0 zero.
- R13: With `valid_i` low, nothing traps, retires or redirects, and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present at commit |
| pc_i | input | 32 | PC of that instruction |
| csr_req_i | input | 1 | Instruction is a CSR access |
| csr_op_i | input | 2 | 0 write, 1 set, 2 clear, 3 read |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR operand |
| ecall_i | input | 1 | Instruction is an environment call |
| mret_i | input | 1 | Instruction is a return-from-trap |
| illegal_i | input | 1 | Decoder flagged the instruction illegal |
| timer_irq_i | input | 1 | Timer interrupt request |
| csr_rdata_o | output | 32 | Old value of the addressed CSR |
| retire_o | output | 1 | Instruction retires this cycle |
| trap_o | output | 1 | Trap taken this cycle |
| redirect_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | 32 | Redirect target |
| priv_o | output | 2 | Current privilege, 2'b11 machine, 2'b00 user |

## Verification
The decision outputs `trap_o`, `retire_o`, `redirect_o`, `redirect_pc_o` and `csr_rdata_o` are combinational, so they are due in the same cycle the instruction is presented. The bench drives each instruction on the falling edge and compares these outputs 1 ns later, before the rising edge. Every state effect (privilege, CSR contents) is due one edge later. It is checked through `priv_o` and through CSR reads issued as later instructions, which the bench compares against a reference model that it advances only after the rising edge.

// File: rtl/mtc_pkg.sv
`timescale 1ns/1ps
package mtc_pkg;
  localparam int XLEN = 32;
  localparam int AW   = 12;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_SET = 2'd1;
  localparam logic [1:0] OP_CLR = 2'd2;
  localparam logic [1:0] OP_RD  = 2'd3;

  localparam logic [AW-1:0] A_STATUS = 12'h300;
  localparam logic [AW-1:0] A_TVEC   = 12'h305;
  localparam logic [AW-1:0] A_EPC    = 12'h341;
  localparam logic [AW-1:0] A_CAUSE  = 12'h342;

  localparam int B_IE   = 3;
  localparam int B_PIE  = 7;
  localparam int B_PP_L = 11;

  localparam logic [XLEN-1:0] C_ILLEGAL = 32'd2;
  localparam logic [XLEN-1:0] C_ECALL_U = 32'd8;
  localparam logic [XLEN-1:0] C_ECALL_M = 32'd11;
  localparam logic [XLEN-1:0] C_TIMER   = {1'b1, 27'd0, 4'd7};

  typedef struct packed {
    logic            exc;
    logic            irq;
    logic [XLEN-1:0] cause;
  } trap_dec_t;

  function automatic logic csr_known(input logic [AW-1:0] a);
    return (a == A_STATUS) || (a == A_TVEC) || (a == A_EPC) || (a == A_CAUSE);
  endfunction

  function automatic logic [XLEN-1:0] csr_apply(input logic [1:0] op,
                                                input logic [XLEN-1:0] old,
                                                input logic [XLEN-1:0] wd);
    case (op)
      OP_WR:   return wd;
      OP_SET:  return old | wd;
      OP_CLR:  return old & ~wd;
      default: return old;
    endcase
  endfunction
endpackage

// File: rtl/mtc_trap_decide.sv
`timescale 1ns/1ps
module mtc_trap_decide
  import mtc_pkg::*;
(
  input  logic          valid_i,
  input  logic [1:0]    priv_i,
  input  logic          mie_i,
  input  logic          csr_req_i,
  input  logic [AW-1:0] csr_addr_i,
  input  logic          mret_i,
  input  logic          ecall_i,
  input  logic          illegal_i,
  input  logic          timer_irq_i,
  output trap_dec_t     dec_o,
  output logic          do_csr_o,
  output logic          do_mret_o
);
  logic user, bad_insn, exc, irq;

  assign user = (priv_i == PRIV_U);

  // privilege and address faults all fold into illegal-instruction
  assign bad_insn = illegal_i
                  | (csr_req_i & (user | ~csr_known(csr_addr_i)))
                  | (mret_i & user);

  assign exc = valid_i & (bad_insn | ecall_i);
  // interrupt only at a boundary, and exceptions win
  assign irq = valid_i & ~exc & timer_irq_i & (mie_i | user);

  always_comb begin
    dec_o.exc = exc;
    dec_o.irq = irq;
    if (bad_insn)     dec_o.cause = C_ILLEGAL;
    else if (ecall_i) dec_o.cause = user ? C_ECALL_U : C_ECALL_M;
    else              dec_o.cause = C_TIMER;
  end

  assign do_csr_o  = valid_i & csr_req_i & ~exc & ~irq;
  assign do_mret_o = valid_i & mret_i & ~exc & ~irq;
endmodule

// File: rtl/mtc_csr_file.sv
`timescale 1ns/1ps
module mtc_csr_file
  import mtc_pkg::*;
#(
  parameter logic [XLEN-1:0] TVEC_RST = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            trap_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_pc_i,
  input  logic            do_mret_i,
  input  logic            do_csr_i,
  input  logic [1:0]      csr_op_i,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic [XLEN-1:0] tvec_o,
  output logic [XLEN-1:0] epc_o,
  output logic [1:0]      priv_o,
  output logic            mie_o,
  output logic [1:0]      mpp_o
);
  logic [1:0]       priv_q, mpp_q;
  logic             mie_q, mpie_q;
  logic [XLEN-1:2]  tvec_q, epc_q;
  logic [XLEN-1:0]  cause_q;
  logic [XLEN-1:0]  status_rd, nv;

  always_comb begin
    status_rd = '0;
    status_rd[B_IE]            = mie_q;
    status_rd[B_PIE]           = mpie_q;
    status_rd[B_PP_L+1:B_PP_L] = mpp_q;
  end

  always_comb begin
    case (csr_addr_i)
      A_STATUS: csr_rdata_o = status_rd;
      A_TVEC:   csr_rdata_o = {tvec_q, 2'b00};
      A_EPC:    csr_rdata_o = {epc_q, 2'b00};
      A_CAUSE:  csr_rdata_o = cause_q;
      default:  csr_rdata_o = '0;
    endcase
  end

  assign nv = csr_apply(csr_op_i, csr_rdata_o, csr_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q  <= PRIV_M;
      mie_q   <= 1'b0;
      mpie_q  <= 1'b0;
      mpp_q   <= PRIV_U;
      tvec_q  <= TVEC_RST[XLEN-1:2];
      epc_q   <= '0;
      cause_q <= '0;
    end else if (trap_i) begin
      epc_q   <= trap_pc_i[XLEN-1:2];
      cause_q <= trap_cause_i;
      mpie_q  <= mie_q;
      mie_q   <= 1'b0;
      mpp_q   <= priv_q;
      priv_q  <= PRIV_M;
    end else if (do_mret_i) begin
      priv_q  <= mpp_q;
      mie_q   <= mpie_q;
      mpie_q  <= 1'b1;
      mpp_q   <= PRIV_U;
    end else if (do_csr_i && csr_op_i != OP_RD) begin
      case (csr_addr_i)
        A_STATUS: begin
          mie_q  <= nv[B_IE];
          mpie_q <= nv[B_PIE];
          mpp_q  <= (nv[B_PP_L+1:B_PP_L] == PRIV_M) ? PRIV_M : PRIV_U;
        end
        A_TVEC:  tvec_q  <= nv[XLEN-1:2];
        A_EPC:   epc_q   <= nv[XLEN-1:2];
        A_CAUSE: cause_q <= nv;
        default: ;
      endcase
    end
  end

  assign tvec_o = {tvec_q, 2'b00};
  assign epc_o  = {epc_q, 2'b00};
  assign priv_o = priv_q;
  assign mie_o  = mie_q;
  assign mpp_o  = mpp_q;
endmodule

// File: rtl/mtrap_csr_unit.sv
`timescale 1ns/1ps
module mtrap_csr_unit
  import mtc_pkg::*;
#(
  parameter logic [31:0] TVEC_RST = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] pc_i,
  input  logic        csr_req_i,
  input  logic [1:0]  csr_op_i,
  input  logic [11:0] csr_addr_i,
  input  logic [31:0] csr_wdata_i,
  input  logic        ecall_i,
  input  logic        mret_i,
  input  logic        illegal_i,
  input  logic        timer_irq_i,
  output logic [31:0] csr_rdata_o,
  output logic        retire_o,
  output logic        trap_o,
  output logic        redirect_o,
  output logic [31:0] redirect_pc_o,
  output logic [1:0]  priv_o
);
  trap_dec_t         dec;
  logic              do_csr, do_mret, mie, take;
  logic [1:0]        mpp;
  logic [XLEN-1:0]   tvec, epc_rd;

  mtc_trap_decide i_decide (
    .valid_i     (valid_i),
    .priv_i      (priv_o),
    .mie_i       (mie),
    .csr_req_i   (csr_req_i),
    .csr_addr_i  (csr_addr_i),
    .mret_i      (mret_i),
    .ecall_i     (ecall_i),
    .illegal_i   (illegal_i),
    .timer_irq_i (timer_irq_i),
    .dec_o       (dec),
    .do_csr_o    (do_csr),
    .do_mret_o   (do_mret)
  );

  assign take = dec.exc | dec.irq;

  mtc_csr_file #(.TVEC_RST(TVEC_RST)) i_csrs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trap_i       (take),
    .trap_cause_i (dec.cause),
    .trap_pc_i    (pc_i),
    .do_mret_i    (do_mret),
    .do_csr_i     (do_csr),
    .csr_op_i     (csr_op_i),
    .csr_addr_i   (csr_addr_i),
    .csr_wdata_i  (csr_wdata_i),
    .csr_rdata_o  (csr_rdata_o),
    .tvec_o       (tvec),
    .epc_o        (epc_rd),
    .priv_o       (priv_o),
    .mie_o        (mie),
    .mpp_o        (mpp)
  );

  assign trap_o        = take;
  assign retire_o      = valid_i & ~take;
  assign redirect_o    = take | do_mret;
  assign redirect_pc_o = take ? tvec : epc_rd;
endmodule

// File: rtl/mtc_unit_chk.sv
`timescale 1ns/1ps
module mtc_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] pc_i,
  input logic        csr_req_i,
  input logic        ecall_i,
  input logic        mret_i,
  input logic        trap_o,
  input logic        retire_o,
  input logic        redirect_o,
  input logic [1:0]  priv_o,
  input logic        mie,
  input logic [1:0]  mpp,
  input logic [31:0] epc_rd
);
  // R6
  trap_to_machine_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> priv_o == 2'b11);

  // R7
  trap_masks_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> !mie);

  // R6
  trap_saves_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> epc_rd == {$past(pc_i[31:2]), 2'b00});

  // R4
  user_csr_faults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && csr_req_i && priv_o == 2'b00) |-> (trap_o && !retire_o));

  // R5
  ecall_traps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ecall_i) |-> trap_o);

  // R8
  mret_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_o && mret_i) |=> priv_o == $past(mpp));

  // R13
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!trap_o && !retire_o && !redirect_o));

  // R6
  trap_or_retire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trap_o, retire_o}));
endmodule

bind mtrap_csr_unit mtc_unit_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .pc_i       (pc_i),
  .csr_req_i  (csr_req_i),
  .ecall_i    (ecall_i),
  .mret_i     (mret_i),
  .trap_o     (trap_o),
  .retire_o   (retire_o),
  .redirect_o (redirect_o),
  .priv_o     (priv_o),
  .mie        (mie),
  .mpp        (mpp),
  .epc_rd     (epc_rd)
);

// File: tb/test_mtrap_csr_unit.sv
`timescale 1ns/1ps
module test_mtrap_csr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid, csr_req, ecall, mret, ill, tmr;
  logic [31:0] pc, wdata;
  logic [1:0]  op;
  logic [11:0] addr;
  logic [31:0] rdata, rpc;
  logic        retire, trap, redir;
  logic [1:0]  priv;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mtrap_csr_unit i_mtrap_csr_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .pc_i(pc),
    .csr_req_i(csr_req), .csr_op_i(op), .csr_addr_i(addr), .csr_wdata_i(wdata),
    .ecall_i(ecall), .mret_i(mret), .illegal_i(ill), .timer_irq_i(tmr),
    .csr_rdata_o(rdata), .retire_o(retire), .trap_o(trap), .redirect_o(redir),
    .redirect_pc_o(rpc), .priv_o(priv)
  );

  // reference state
  logic [1:0]  m_priv, m_mpp;
  logic        m_mie, m_mpie;
  logic [31:0] m_tvec, m_epc, m_cause;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic known(input logic [11:0] a);
    return a == 12'h300 || a == 12'h305 || a == 12'h341 || a == 12'h342;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h300: return {19'd0, m_mpp, 3'd0, m_mpie, 3'd0, m_mie, 3'd0};
      12'h305: return m_tvec;
      12'h341: return m_epc;
      12'h342: return m_cause;
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_reset();
    m_priv = 2'b11; m_mpp = 2'b00; m_mie = 1'b0; m_mpie = 1'b0;
    m_tvec = 0; m_epc = 0; m_cause = 0;
  endtask

  task automatic step(input logic v, input logic [31:0] p, input logic c, input logic [1:0] o,
                      input logic [11:0] a, input logic [31:0] wd, input logic ec,
                      input logic mr, input logic il, input logic tm);
    logic user, bad, exc, irq, ret, do_mret;
    logic [31:0] cause, old, nv;
    string tag;
    @(negedge clk);
    valid = v; pc = p; csr_req = c; op = o; addr = a; wdata = wd;
    ecall = ec; mret = mr; ill = il; tmr = tm;
    #1;
    user = (m_priv == 2'b00);
    bad  = il | (c & (user | !known(a))) | (mr & user);
    exc  = v & (bad | ec);
    irq  = v & !exc & tm & (m_mie | user);
    ret  = v & !exc & !irq;
    do_mret = ret & mr;
    cause = bad ? 32'd2 : ec ? (user ? 32'd8 : 32'd11) : 32'h8000_0007;
    if (!v)                         tag = "R13";
    else if (exc && tm && (m_mie || user)) tag = "R10";
    else if (exc && il)             tag = "R11";
    else if (exc && c && !user && !known(a)) tag = "R3";
    else if (exc && bad)            tag = "R4";
    else if (exc)                   tag = "R5";
    else if (irq)                   tag = "R9";
    else if (do_mret)               tag = "R8";
    else if (ret && c)              tag = "R2";
    else                            tag = "R6";
    chk(tag, "priv", {30'd0, priv}, {30'd0, m_priv});
    chk(tag, "trap", {31'd0, trap}, {31'd0, exc | irq});
    chk(tag, "retire", {31'd0, retire}, {31'd0, ret});
    chk(tag, "redirect", {31'd0, redir}, {31'd0, exc | irq | do_mret});
    if (exc | irq) chk(tag, "redirect_pc", rpc, m_tvec);
    else if (do_mret) chk(tag, "redirect_pc", rpc, m_epc);
    if (ret && c) chk(tag, "rdata", rdata, m_read(a));
    @(posedge clk);
    if (exc | irq) begin
      m_epc = {p[31:2], 2'b00}; m_cause = cause;
      m_mpie = m_mie; m_mie = 1'b0; m_mpp = m_priv; m_priv = 2'b11;
    end else if (do_mret) begin
      m_priv = m_mpp; m_mie = m_mpie; m_mpie = 1'b1; m_mpp = 2'b00;
    end else if (ret && c && o != 2'd3) begin
      old = m_read(a);
      case (o)
        2'd0: nv = wd;
        2'd1: nv = old | wd;
        default: nv = old & ~wd;
      endcase
      case (a)
        12'h300: begin
          m_mie = nv[3]; m_mpie = nv[7];
          m_mpp = (nv[12:11] == 2'b11) ? 2'b11 : 2'b00; // R12
        end
        12'h305: m_tvec = {nv[31:2], 2'b00};
        12'h341: m_epc  = {nv[31:2], 2'b00};
        default: m_cause = nv;
      endcase
    end
  endtask

  task automatic csr(input logic [1:0] o, input logic [11:0] a, input logic [31:0] wd);
    step(1, 32'h0000_0400, 1, o, a, wd, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      summary();
    end
  end

  initial begin
    logic [31:0] r;
    valid = 0; pc = 0; csr_req = 0; op = 0; addr = 0; wdata = 0;
    ecall = 0; mret = 0; ill = 0; tmr = 0;
    m_reset();
    r = $urandom(32'd20210);
    #9;
    chk("R1", "priv in reset", {30'd0, priv}, 32'd3);
    rst_n = 1'b1;
    // R1: every CSR reads zero after reset
    csr(2'd3, 12'h300, 0);
    csr(2'd3, 12'h305, 0);
    csr(2'd3, 12'h341, 0);
    csr(2'd3, 12'h342, 0);
    // R12: handler base low bits dropped
    csr(2'd0, 12'h305, 32'h0000_1003);
    csr(2'd3, 12'h305, 0);
    // R2: set then clear bits
    csr(2'd1, 12'h300, 32'h8);
    csr(2'd3, 12'h300, 0);
    // R12: saved privilege 01 becomes 00
    csr(2'd0, 12'h300, 32'h0000_0808);
    csr(2'd3, 12'h300, 0);
    csr(2'd2, 12'h300, 32'h8);
    csr(2'd1, 12'h300, 32'h8);
    // R5 R6 R7: ecall from machine mode
    step(1, 32'h0000_0100, 0, 0, 0, 0, 1, 0, 0, 0);
    csr(2'd3, 12'h300, 0);
    csr(2'd3, 12'h342, 0);
    csr(2'd3, 12'h341, 0);
    // R12: return address low bits dropped; R8: return to user
    csr(2'd0, 12'h341, 32'h0000_0203);
    csr(2'd0, 12'h300, 32'h0000_0080);
    step(1, 32'h0000_0104, 0, 0, 0, 0, 0, 1, 0, 0);
    // R4: CSR access from user
    step(1, 32'h0000_0204, 1, 2'd0, 12'h305, 32'hFFFF_FFFF, 0, 0, 0, 0);
    csr(2'd3, 12'h305, 0);
    csr(2'd3, 12'h342, 0);
    // R9: timer ignored in machine mode with enable clear
    step(1, 32'h0000_0108, 0, 0, 0, 0, 0, 0, 0, 1);
    // R13: idle cycle with requests
    step(0, 32'h0000_010C, 1, 2'd0, 12'h342, 32'h5, 1, 1, 1, 1);
    csr(2'd3, 12'h342, 0);
    // R3: unknown address
    csr(2'd0, 12'h301, 32'h1);
    // R11: illegal ahead of ecall
    step(1, 32'h0000_0110, 0, 0, 0, 0, 1, 0, 1, 0);
    // back to user, then R10: ecall with timer
    csr(2'd0, 12'h341, 32'h0000_0300);
    csr(2'd0, 12'h300, 32'h0);
    step(1, 32'h0000_0114, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 32'h0000_0300, 0, 0, 0, 0, 1, 0, 0, 1);
    csr(2'd3, 12'h342, 0);
    // R9: timer from user
    csr(2'd0, 12'h300, 32'h0);
    step(1, 32'h0000_0118, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 32'h0000_0304, 0, 0, 0, 0, 0, 0, 0, 1);
    csr(2'd3, 12'h342, 0);
    // R4: return-from-trap in user
    csr(2'd0, 12'h300, 32'h0);
    step(1, 32'h0000_011C, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 32'h0000_0308, 0, 0, 0, 0, 0, 1, 0, 0);
    csr(2'd3, 12'h341, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [11:0] ra;
      k = $urandom_range(0, 15);
      case ($urandom_range(0, 4))
        0: ra = 12'h300;
        1: ra = 12'h305;
        2: ra = 12'h341;
        3: ra = 12'h342;
        default: ra = ($urandom_range(0, 3) == 0) ? 12'h7C0 : 12'h300;
      endcase
      step($urandom_range(0, 9) != 0, $urandom, k < 8, 2'($urandom_range(0, 3)), ra,
           (ra == 12'h300) ? ($urandom & 32'h0000_1888) : $urandom,
           k == 8 || k == 9, k >= 10 && k <= 12, k == 13, $urandom_range(0, 7) == 0);
    end
    done = 1'b1;
    summary();
  end
endmodule